// File: doc/BRIEF.md
# Registered-Module Power and Self-Refresh Sequencer

This block is a synchronous controller for a registered DDR memory module. It runs the power-up sequence and both optional self-refresh flows. It drives the module's active-low asynchronous register reset, an enable that gates the module clock, CKE, and the command lines (chip select, row strobe, column strobe, write enable). Every wait in a sequence is a parameter counted in controller clock cycles, and one shared countdown timer times them all.

On power-up the clock is enabled first. The module reset stays low through the PLL lock wait and the SDRAM stabilisation wait. When the reset is released, CKE is kept low for the register activation time, and then the controller reports that the module is ready. A self-refresh request issues the entry command. Because the module register delays every command by one cycle, the controller waits one more cycle before it lowers the module reset. It then holds the clock and a deselect command for the register deactivation time before it releases the command lines. If the clock-stop mode was selected when the request was taken, the clock is also stopped at that point.

On a wake request the sequence runs in reverse. In clock-stop mode the clock is restarted and the PLL wait is repeated first. In both modes one deselect cycle comes before the reset rises, and the activation time is observed again before the controller is ready.

Top module: `rdimm_pwr_seq`

## Requirements
- R1: While the controller reset `rst_n` is low, and afterwards until `start_i` is seen, the outputs are: module reset low, clock enable low, CKE low, command deselect (cs_n, ras_n, cas_n, we_n = 1,1,1,1) and ready low.
- R2: A `start_i` pulse taken in the idle state enables the clock in the next cycle. The module reset then stays low for exactly T_PLL+T_STAB cycles, counted from that cycle, with CKE low and the command at deselect.
- R3: After the module reset rises, CKE stays low for exactly T_ACT cycles. After that, CKE is high, ready is high and the command is NOP (0,1,1,1). Ready is never high unless CKE, the module reset and the clock enable are all high.
- R4: A self-refresh request taken in the ready state produces one cycle of the entry command, with CKE low and the command at (0,0,0,1), while the module reset is still high. One deselect cycle with the module reset still high follows, and only then does the module reset go low.
- R5: After the module reset goes low on entry, the clock stays enabled and the command stays at deselect for exactly T_INACT cycles. Then the command lines are released low (0,0,0,0), and the clock enable becomes the inverse of the mode bit that was sampled when the request was taken.
- R6: The clock enable is never low while the module reset is high, and CKE is never high while the module reset is low.
- R7: In clock-stop mode, a wake request enables the clock in the next cycle. The module reset then stays low with deselect for T_PLL+1 cycles before it rises, and the T_ACT wait of R3 follows.
- R8: In clock-running mode, a wake request gives exactly one deselect cycle with the module reset low before the reset rises. In every flow, the cycle before the module reset rises carries deselect with CKE low.
- R9: A self-refresh request that arrives during power-up is remembered. Ready is then high for exactly one cycle before the entry command of R4 is issued.
- R10: These inputs have no effect: wake and start while ready; a self-refresh request while the module is in self-refresh or waking; and a change of the mode bit while in self-refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Controller reset, active low, asynchronous |
| start_i | input | 1 | Start power-up (pulse) |
| sr_req_i | input | 1 | Request self-refresh entry (pulse) |
| wake_i | input | 1 | Request self-refresh exit (pulse) |
| clk_stop_i | input | 1 | 1 = stop module clock during self-refresh |
| mod_rst_n_o | output | 1 | Module register reset, active low |
| clk_run_o | output | 1 | Module clock enable |
| cke_o | output | 1 | Clock enable to the SDRAMs |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ready_o | output | 1 | Module initialised and ready |

## Verification
The assertions check on every cycle the relations between the module pins that must always hold. Specifically, they check the forbidden clock-off/reset-high pairing and CKE high under reset. They also check that the entry command is followed by a deselect cycle with the reset still high, and that the cycle before any reset release is quiet. Counters in the checker additionally measure the activation window before CKE rises and the deactivation window before the clock stops. What only the bench scenarios can show is the exact length of each phase after a given request. They also show that a request made during power-up is carried over, and that the wake, start, request and mode inputs are ignored in the states where they must be. Only an observed sequence of pins after chosen stimulus reveals these.

// File: rtl/rdimm_seq_pkg.sv
package rdimm_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PU_PLL,
    ST_PU_STAB,
    ST_PU_ACT,
    ST_READY,
    ST_SR_CMD,
    ST_SR_PIPE,
    ST_SR_INACT,
    ST_SR_HOLD,
    ST_SX_PLL,
    ST_SX_PREP,
    ST_SX_ACT
  } seq_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  typedef struct packed {
    logic mod_rst_n;
    logic clk_run;
    logic cke;
    cmd_t cmd;
    logic ready;
  } pins_t;

  localparam cmd_t CMD_DESEL = cmd_t'(4'b1111);
  localparam cmd_t CMD_NOP   = cmd_t'(4'b0111);
  localparam cmd_t CMD_SRE   = cmd_t'(4'b0001);
  localparam cmd_t CMD_LOW   = cmd_t'(4'b0000);

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Counter width able to hold the value m.
  function automatic int unsigned ctr_width(input int unsigned m);
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // A wait of dur cycles loads dur-1: the state lasts while the count runs down to zero.
  function automatic int unsigned wait_load(input int unsigned dur);
    return (dur == 0) ? 0 : dur - 1;
  endfunction

  function automatic logic in_power_up(input seq_st_e s);
    return (s == ST_PU_PLL) || (s == ST_PU_STAB) || (s == ST_PU_ACT);
  endfunction

  function automatic logic is_timed(input seq_st_e s);
    case (s)
      ST_PU_PLL, ST_PU_STAB, ST_PU_ACT,
      ST_SR_INACT, ST_SX_PLL, ST_SX_ACT: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rdimm_seq_timer.sv
module rdimm_seq_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rdimm_seq_req.sv
module rdimm_seq_req (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic accept_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (take_i)              pend_q <= 1'b0;
    else if (req_i && accept_i)   pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/rdimm_seq_fsm.sv
module rdimm_seq_fsm
  import rdimm_seq_pkg::*;
#(
  parameter int unsigned T_PLL   = 20000,
  parameter int unsigned T_STAB  = 40000,
  parameter int unsigned T_ACT   = 16,
  parameter int unsigned T_INACT = 16,
  parameter int unsigned TW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          sr_go_i,
  input  logic          wake_i,
  input  logic          clk_stop_i,
  input  logic          tmr_done_i,
  output seq_st_e       st_o,
  output logic          stop_lat_o,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          sr_take_o
);
  localparam logic [TW-1:0] LD_PLL   = TW'(wait_load(T_PLL));
  localparam logic [TW-1:0] LD_STAB  = TW'(wait_load(T_STAB));
  localparam logic [TW-1:0] LD_ACT   = TW'(wait_load(T_ACT));
  localparam logic [TW-1:0] LD_INACT = TW'(wait_load(T_INACT));

  seq_st_e st_q, st_nxt;
  logic    stop_q;

  assign sr_take_o = (st_q == ST_READY) && sr_go_i;

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_OFF:      if (start_i)    st_nxt = ST_PU_PLL;
      ST_PU_PLL:   if (tmr_done_i) st_nxt = ST_PU_STAB;
      ST_PU_STAB:  if (tmr_done_i) st_nxt = ST_PU_ACT;
      ST_PU_ACT:   if (tmr_done_i) st_nxt = ST_READY;
      ST_READY:    if (sr_go_i)    st_nxt = ST_SR_CMD;
      ST_SR_CMD:                   st_nxt = ST_SR_PIPE;
      ST_SR_PIPE:                  st_nxt = ST_SR_INACT;
      ST_SR_INACT: if (tmr_done_i) st_nxt = ST_SR_HOLD;
      ST_SR_HOLD:  if (wake_i)     st_nxt = stop_q ? ST_SX_PLL : ST_SX_PREP;
      ST_SX_PLL:   if (tmr_done_i) st_nxt = ST_SX_PREP;
      ST_SX_PREP:                  st_nxt = ST_SX_ACT;
      ST_SX_ACT:   if (tmr_done_i) st_nxt = ST_READY;
      default:                     st_nxt = ST_OFF;
    endcase
  end

  always_comb begin
    case (st_nxt)
      ST_PU_PLL, ST_SX_PLL: tmr_val_o = LD_PLL;
      ST_PU_STAB:           tmr_val_o = LD_STAB;
      ST_SR_INACT:          tmr_val_o = LD_INACT;
      default:              tmr_val_o = LD_ACT;
    endcase
  end

  assign tmr_load_o = (st_nxt != st_q) && is_timed(st_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      stop_q <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (sr_take_o) stop_q <= clk_stop_i;
    end
  end

  assign st_o       = st_q;
  assign stop_lat_o = stop_q;
endmodule

// File: rtl/rdimm_seq_drv.sv
module rdimm_seq_drv
  import rdimm_seq_pkg::*;
(
  input  seq_st_e st_i,
  input  logic    stop_lat_i,
  output pins_t   pins_o
);
  always_comb begin
    pins_o = '{mod_rst_n: 1'b0, clk_run: 1'b0, cke: 1'b0, cmd: CMD_DESEL, ready: 1'b0};
    case (st_i)
      ST_OFF: ;
      ST_PU_PLL, ST_PU_STAB, ST_SR_INACT, ST_SX_PLL, ST_SX_PREP:
        pins_o.clk_run = 1'b1;
      ST_PU_ACT, ST_SR_PIPE, ST_SX_ACT: begin
        pins_o.clk_run   = 1'b1;
        pins_o.mod_rst_n = 1'b1;
      end
      ST_READY: begin
        pins_o.clk_run   = 1'b1;
        pins_o.mod_rst_n = 1'b1;
        pins_o.cke       = 1'b1;
        pins_o.cmd       = CMD_NOP;
        pins_o.ready     = 1'b1;
      end
      ST_SR_CMD: begin
        pins_o.clk_run   = 1'b1;
        pins_o.mod_rst_n = 1'b1;
        pins_o.cmd       = CMD_SRE;
      end
      ST_SR_HOLD: begin
        pins_o.clk_run = !stop_lat_i;
        pins_o.cmd     = CMD_LOW;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rdimm_pwr_seq.sv
module rdimm_pwr_seq
  import rdimm_seq_pkg::*;
#(
  parameter int unsigned T_PLL   = 20000,
  parameter int unsigned T_STAB  = 40000,
  parameter int unsigned T_ACT   = 16,
  parameter int unsigned T_INACT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sr_req_i,
  input  logic wake_i,
  input  logic clk_stop_i,
  output logic mod_rst_n_o,
  output logic clk_run_o,
  output logic cke_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic ready_o
);
  localparam int unsigned TMAX = max4(T_PLL, T_STAB, T_ACT, T_INACT);
  localparam int unsigned TW   = ctr_width(TMAX);

  seq_st_e       st;
  logic          stop_lat;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;
  logic          sr_pend;
  logic          sr_go;
  logic          sr_take;
  pins_t         pins;

  assign sr_go = sr_req_i || sr_pend;

  rdimm_seq_req u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (sr_req_i),
    .accept_i (in_power_up(st)),
    .take_i   (sr_take),
    .pend_o   (sr_pend)
  );

  rdimm_seq_timer #(.W(TW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  rdimm_seq_fsm #(
    .T_PLL(T_PLL), .T_STAB(T_STAB), .T_ACT(T_ACT), .T_INACT(T_INACT), .TW(TW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .sr_go_i    (sr_go),
    .wake_i     (wake_i),
    .clk_stop_i (clk_stop_i),
    .tmr_done_i (tmr_done),
    .st_o       (st),
    .stop_lat_o (stop_lat),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .sr_take_o  (sr_take)
  );

  rdimm_seq_drv u_drv (
    .st_i       (st),
    .stop_lat_i (stop_lat),
    .pins_o     (pins)
  );

  assign mod_rst_n_o = pins.mod_rst_n;
  assign clk_run_o   = pins.clk_run;
  assign cke_o       = pins.cke;
  assign cs_n_o      = pins.cmd.cs_n;
  assign ras_n_o     = pins.cmd.ras_n;
  assign cas_n_o     = pins.cmd.cas_n;
  assign we_n_o      = pins.cmd.we_n;
  assign ready_o     = pins.ready;
endmodule

// File: rtl/rdimm_pwr_seq_chk.sv
module rdimm_pwr_seq_chk #(
  parameter int unsigned T_ACT   = 16,
  parameter int unsigned T_INACT = 16
) (
  input logic clk,
  input logic rst_n,
  input logic mod_rst_n,
  input logic clk_run,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic ready,
  input logic sr_take
);
  localparam int unsigned CW = 16;
  localparam logic [CW-1:0] CAP = '1;

  logic [CW-1:0] act_cnt, low_cnt;
  logic desel, sre;

  assign desel = cs_n && ras_n && cas_n && we_n;
  assign sre   = !cke && !cs_n && !ras_n && !cas_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cnt <= '0;
      low_cnt <= '0;
    end else begin
      if (mod_rst_n && !cke) act_cnt <= (act_cnt == CAP) ? CAP : act_cnt + 1'b1;
      else                   act_cnt <= '0;
      if (!mod_rst_n)        low_cnt <= (low_cnt == CAP) ? CAP : low_cnt + 1'b1;
      else                   low_cnt <= '0;
    end
  end

  AST_CLK_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst_n |-> clk_run);  // R6
  AST_CKE_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_rst_n |-> !cke);  // R6
  AST_READY_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cke && mod_rst_n && clk_run));  // R3
  AST_ACT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (act_cnt == CW'(T_ACT)));  // R3
  AST_SRE_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_take |=> (sre && mod_rst_n));  // R4
  AST_SRE_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sre |-> $past(ready));  // R4
  AST_PIPE_AFTER_SRE: assert property (@(posedge clk) disable iff (!rst_n)
    sre |=> (mod_rst_n && !cke && desel));  // R4
  AST_RST_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_rst_n) |-> ($past(desel) && $past(mod_rst_n)));  // R4
  AST_INACT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_run) |-> (!mod_rst_n && low_cnt >= CW'(T_INACT)));  // R5
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_rst_n) |-> ($past(desel) && !$past(cke) && clk_run));  // R8
endmodule

bind rdimm_pwr_seq rdimm_pwr_seq_chk #(.T_ACT(T_ACT), .T_INACT(T_INACT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mod_rst_n (mod_rst_n_o),
  .clk_run   (clk_run_o),
  .cke       (cke_o),
  .cs_n      (cs_n_o),
  .ras_n     (ras_n_o),
  .cas_n     (cas_n_o),
  .we_n      (we_n_o),
  .ready     (ready_o),
  .sr_take   (sr_take)
);

// File: tb/rdimm_pwr_seq_test.sv
module rdimm_pwr_seq_test;
  localparam int T_PLL = 5, T_STAB = 7, T_ACT = 3, T_INACT = 4;
  localparam logic [7:0] P_OFF   = 8'b0_0_0_1111_0;
  localparam logic [7:0] P_READY = 8'b1_1_1_0111_1;
  localparam logic [7:0] P_SRE   = 8'b1_1_0_0001_0;
  localparam logic [7:0] P_PIPE  = 8'b1_1_0_1111_0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, sr_req_i = 0, wake_i = 0, clk_stop_i = 0;
  logic mod_rst_n_o, clk_run_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ready_o;
  int checks = 0, fails = 0, bad6 = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rdimm_pwr_seq #(.T_PLL(T_PLL), .T_STAB(T_STAB), .T_ACT(T_ACT), .T_INACT(T_INACT)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sr_req_i(sr_req_i), .wake_i(wake_i),
    .clk_stop_i(clk_stop_i), .mod_rst_n_o(mod_rst_n_o), .clk_run_o(clk_run_o),
    .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .ready_o(ready_o));

  function automatic logic [7:0] obs();
    return {mod_rst_n_o, clk_run_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ready_o};
  endfunction

  function automatic logic [7:0] hold_pat(input logic stop);
    return {1'b0, !stop, 6'b0};
  endfunction

  always @(negedge clk)
    if (rst_n && ((mod_rst_n_o && !clk_run_o) || (cke_o && !mod_rst_n_o))) bad6++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Counts samples with module reset low; inject_sr raises a request mid-way.
  task automatic count_low(input bit inject_sr, output int n, output int bad);
    n = 0; bad = 0;
    while (!mod_rst_n_o && n < 1000) begin
      if (!clk_run_o || cke_o || !cs_n_o || !ras_n_o || !cas_n_o || !we_n_o) bad++;
      sr_req_i = inject_sr && (n == 2);
      n++;
      tick();
    end
    sr_req_i = 0;
  endtask

  task automatic count_act(output int m);
    m = 0;
    while (mod_rst_n_o && !cke_o && m < 1000) begin m++; tick(); end
  endtask

  task automatic power_up(input bit inject_sr);
    int n, bad, m;
    start_i = 1; tick(); start_i = 0;
    count_low(inject_sr, n, bad);
    chk("R2 low-reset cycles", n, T_PLL + T_STAB);
    chk("R2 clock/cke/deselect during wait", bad, 0);
    count_act(m);
    chk("R3 activation cycles", m, T_ACT);
    chk("R3 ready pins", obs(), P_READY);
  endtask

  task automatic sr_after_cmd(input logic mode);
    int n, bad, m, stray;
    tick();
    chk("R4 pipeline cycle", obs(), P_PIPE);
    tick();
    n = 0; bad = 0;
    while (!mod_rst_n_o && cs_n_o && n < 1000) begin
      if (!clk_run_o || cke_o) bad++;
      n++; tick();
    end
    chk("R5 deactivation cycles", n, T_INACT);
    chk("R5 clock kept during deactivation", bad, 0);
    chk("R5 hold pins", obs(), hold_pat(mode));
    stray = 0;
    clk_stop_i = !mode;
    for (int i = 0; i < 4; i++) begin
      sr_req_i = (i == 1);
      tick();
      if (obs() != hold_pat(mode)) stray++;
    end
    sr_req_i = 0;
    chk("R10 request/mode ignored in self-refresh", stray, 0);
    wake_i = 1; tick(); wake_i = 0;
    count_low(1'b0, n, bad);
    if (mode) chk("R7 clock-stop wake reset-low cycles", n, T_PLL + 1);
    else      chk("R8 clock-run wake reset-low cycles", n, 1);
    chk(mode ? "R7 wake deselect" : "R8 wake deselect", bad, 0);
    count_act(m);
    chk(mode ? "R7 activation after wake" : "R8 activation after wake", m, T_ACT);
    chk("R3 ready after wake", obs(), P_READY);
    stray = 0;
    for (int i = 0; i < 5; i++) begin tick(); if (obs() != P_READY) stray++; end
    chk("R10 no stale request after wake", stray, 0);
  endtask

  task automatic sr_cycle(input logic mode);
    clk_stop_i = mode; sr_req_i = 1; tick(); sr_req_i = 0;
    chk("R4 entry command", obs(), P_SRE);
    sr_after_cmd(mode);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int stray;
    repeat (3) tick();
    chk("R1 pins in reset", obs(), P_OFF);
    rst_n = 1;
    repeat (4) tick();
    chk("R1 idle without start", obs(), P_OFF);

    power_up(1'b0);

    stray = 0;
    for (int i = 0; i < 6; i++) begin
      wake_i = (i == 0); start_i = (i == 2);
      tick();
      if (obs() != P_READY) stray++;
    end
    wake_i = 0; start_i = 0;
    chk("R10 wake/start ignored when ready", stray, 0);

    for (int mode = 0; mode < 2; mode++)
      for (int rep = 0; rep < 2; rep++)
        sr_cycle(mode[0]);

    rst_n = 0; #1;
    chk("R1 pins on controller reset", obs(), P_OFF);
    tick(); rst_n = 1; tick();
    chk("R1 idle after reset release", obs(), P_OFF);

    clk_stop_i = 1;
    power_up(1'b1);
    tick();
    chk("R9 held request issued after one ready cycle", obs(), P_SRE);
    sr_after_cmd(1'b1);

    chk("R6 illegal pin combinations seen", bad6, 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule